// File: doc/BRIEF.md
# Counter-Based All-Digital Clock Loop

This block closes a phase-locked loop entirely in logic on a single fast clock. A reference clock, already brought into the fast domain, is compared with a feedback event stream. The feedback stream comes from a numerically controlled oscillator whose pulse rate is divided by a programmable ratio. A three-state detector decides whether the reference or the feedback arrived first. While the detector points one way, a signed counter runs up or down. At each reference edge that count is taken as the phase error of the cycle just ended.

A one-tap integrator adds each phase error into the oscillator's control word. The word is clamped so that it can never wrap. The oscillator is a 5-bit phase accumulator that adds the word on every fast cycle. Each wrap produces a one-cycle pulse on the output clock, so the pulse rate is the word divided by 32 times the fast clock rate. A lock flag reports when the phase error has stayed within a programmable band for four reference cycles in a row.

Top module: `adpll_loop`

## Requirements
- R1: After reset, ctrlWord is 20, locked is 0 and clkOut is 0.
- R2: The oscillator adds ctrlWord into a 5-bit phase register on every cycle. clkOut is high for exactly the one cycle after each wrap. While ctrlWord stays at 20, any 320 consecutive cycles therefore hold exactly 200 high samples of clkOut.
- R3: A reference edge is a cycle in which refIn is 1 after being 0 in the previous cycle. The detector starts idle. From idle, a reference edge alone moves it to up, a feedback pulse alone moves it to down, and both together leave it idle. From up, a feedback pulse returns it to idle. From down, a reference edge returns it to idle. Up and down are never active together.
- R4: The phase counter adds 1 in each cycle spent in up and subtracts 1 in each cycle spent in down, saturating at +511 and -511. In a reference-edge cycle, the value held before that cycle becomes the phase error, and counting restarts from that cycle's own step.
- R5: In each reference-edge cycle, ctrlWord becomes ctrlWord plus the phase error, clamped to 1..31. In every other cycle, ctrlWord keeps its value.
- R6: A feedback pulse occurs once every divN output pulses. A divN of 0 behaves as 1.
- R7: locked rises after 4 consecutive reference edges whose absolute phase error is at or below lockThresh. It falls at the first reference edge whose error exceeds lockThresh. It changes at no other time.
- R8: A reference much slower than the feedback drives ctrlWord down to 1 and holds it there. A reference faster than the divided feedback drives it up to 31 and holds it there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| refIn | input | 1 | Reference clock, already synchronised to clk |
| divN | input | 4 | Feedback division ratio (0 behaves as 1) |
| lockThresh | input | 10 | Largest absolute phase error counted as in band |
| clkOut | output | 1 | Oscillator output, one-cycle pulse per accumulator wrap |
| ctrlWord | output | 5 | Oscillator control word, range 1..31 |
| locked | output | 1 | Lock indication |

## Verification
The hardest states to reach from the ports are the two clamp limits of the control word, because the loop works to keep the word in the middle of its range. The stimulus gets there by setting the reference period far from the divided oscillator period. A very slow reference with divide-by-one keeps every error negative and pins the word at 1. A fast reference with divide-by-eight keeps every error positive and pins it at 31. A behavioural model runs alongside the design through these phases and through zero and small division ratios, and a band change takes the lock flag through both its rise and its fall.

// File: rtl/adpll_pkg.sv
package adpll_pkg;

  typedef enum logic [1:0] {
    PFD_IDLE = 2'd0,
    PFD_UP   = 2'd1,
    PFD_DN   = 2'd2
  } pfdState_e;

  typedef struct packed {
    logic refEdge;
    logic countUp;
    logic countDn;
  } loopStrobe_t;

endpackage

// File: rtl/adpll_ctrl.sv
module adpll_ctrl
  import adpll_pkg::*;
#(
  parameter int ERR_W    = 10,
  parameter int LOCK_RUN = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    refIn,
  input  logic                    fbPulse,
  input  logic signed [ERR_W-1:0] err,
  input  logic [ERR_W-1:0]        lockThresh,
  output loopStrobe_t             strb,
  output logic                    locked
);

  localparam int RUN_W = $clog2(LOCK_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(LOCK_RUN);

  logic      refPrev;
  logic      refEdge;
  pfdState_e pfdState, pfdNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) refPrev <= 1'b0;
    else        refPrev <= refIn;
  end

  assign refEdge = refIn & ~refPrev;

  always_comb begin
    pfdNext = pfdState;
    unique case (pfdState)
      PFD_IDLE: begin
        if (refEdge && !fbPulse)      pfdNext = PFD_UP;
        else if (fbPulse && !refEdge) pfdNext = PFD_DN;
      end
      PFD_UP:  if (fbPulse) pfdNext = PFD_IDLE;
      PFD_DN:  if (refEdge) pfdNext = PFD_IDLE;
      default: pfdNext = PFD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pfdState <= PFD_IDLE;
    else        pfdState <= pfdNext;
  end

  assign strb.refEdge = refEdge;
  assign strb.countUp = (pfdState == PFD_UP);
  assign strb.countDn = (pfdState == PFD_DN);

  // lock qualification: run of in-band reference cycles
  logic [ERR_W-1:0] errRaw, errMag;
  logic             inBand;
  logic [RUN_W-1:0] goodCnt, goodNext;

  always_comb begin
    errRaw   = err;
    errMag   = err[ERR_W-1] ? (~errRaw + 1'b1) : errRaw;
    inBand   = (errMag <= lockThresh);
    if (!inBand)                goodNext = '0;
    else if (goodCnt == RUN_TOP) goodNext = goodCnt;
    else                        goodNext = goodCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      goodCnt <= '0;
      locked  <= 1'b0;
    end else if (refEdge) begin
      goodCnt <= goodNext;
      locked  <= (goodNext == RUN_TOP);
    end
  end

endmodule

// File: rtl/adpll_dp.sv
module adpll_dp
  import adpll_pkg::*;
#(
  parameter int NCO_W     = 5,
  parameter int ERR_W     = 10,
  parameter int DIV_W     = 4,
  parameter int FREE_WORD = 20,
  parameter int WORD_MIN  = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  loopStrobe_t             strb,
  input  logic [DIV_W-1:0]        divN,
  output logic signed [ERR_W-1:0] err,
  output logic [NCO_W-1:0]        ctrlWord,
  output logic                    clkOut,
  output logic                    fbPulse
);

  localparam int WORD_MAX = (2 ** NCO_W) - 1;
  localparam int ERR_MAX  = (2 ** (ERR_W - 1)) - 1;
  localparam int SUM_W    = ERR_W + 2;
  localparam logic signed [ERR_W:0]   LIM_P  = (ERR_W + 1)'(ERR_MAX);
  localparam logic signed [ERR_W:0]   LIM_N  = -(ERR_W + 1)'(ERR_MAX);
  localparam logic signed [ERR_W:0]   STEP_P = (ERR_W + 1)'(1);
  localparam logic signed [ERR_W:0]   STEP_N = -(ERR_W + 1)'(1);
  localparam logic signed [SUM_W-1:0] SMIN   = SUM_W'(WORD_MIN);
  localparam logic signed [SUM_W-1:0] SMAX   = SUM_W'(WORD_MAX);

  // phase counter (time-to-digital)
  logic signed [ERR_W-1:0] tdcCnt, tdcNext;
  logic signed [ERR_W:0]   tdcBase, tdcSum, stepV;

  always_comb begin
    if (strb.countUp)      stepV = STEP_P;
    else if (strb.countDn) stepV = STEP_N;
    else                   stepV = '0;
    tdcBase = strb.refEdge ? '0 : {tdcCnt[ERR_W-1], tdcCnt};
    tdcSum  = tdcBase + stepV;
    if (tdcSum > LIM_P)      tdcNext = LIM_P[ERR_W-1:0];
    else if (tdcSum < LIM_N) tdcNext = LIM_N[ERR_W-1:0];
    else                     tdcNext = tdcSum[ERR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tdcCnt <= '0;
    else        tdcCnt <= tdcNext;
  end

  assign err = tdcCnt;

  // one-tap integrator with clamp
  logic signed [SUM_W-1:0] sumV;
  logic [NCO_W-1:0]        wordNext;

  always_comb begin
    sumV = {{(SUM_W - NCO_W){1'b0}}, ctrlWord}
         + {{(SUM_W - ERR_W){tdcCnt[ERR_W-1]}}, tdcCnt};
    if (sumV < SMIN)      wordNext = NCO_W'(WORD_MIN);
    else if (sumV > SMAX) wordNext = NCO_W'(WORD_MAX);
    else                  wordNext = sumV[NCO_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ctrlWord <= NCO_W'(FREE_WORD);
    else if (strb.refEdge) ctrlWord <= wordNext;
  end

  // phase-accumulator oscillator
  logic [NCO_W-1:0] phase;
  logic [NCO_W:0]   phaseSum;
  logic             wrap;

  assign phaseSum = {1'b0, phase} + {1'b0, ctrlWord};
  assign wrap     = phaseSum[NCO_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= '0;
      clkOut <= 1'b0;
    end else begin
      phase  <= phaseSum[NCO_W-1:0];
      clkOut <= wrap;
    end
  end

  // feedback divider
  logic [DIV_W-1:0] divCnt, divEff;
  logic             divTerm;

  assign divEff  = (divN == '0) ? DIV_W'(1) : divN;
  assign divTerm = (divCnt >= divEff - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divCnt  <= '0;
      fbPulse <= 1'b0;
    end else begin
      fbPulse <= wrap & divTerm;
      if (wrap) divCnt <= divTerm ? '0 : divCnt + 1'b1;
    end
  end

endmodule

// File: rtl/adpll_loop.sv
module adpll_loop
  import adpll_pkg::*;
#(
  parameter int NCO_W     = 5,
  parameter int ERR_W     = 10,
  parameter int DIV_W     = 4,
  parameter int FREE_WORD = 20,
  parameter int LOCK_RUN  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refIn,
  input  logic [DIV_W-1:0] divN,
  input  logic [ERR_W-1:0] lockThresh,
  output logic             clkOut,
  output logic [NCO_W-1:0] ctrlWord,
  output logic             locked
);

  loopStrobe_t             strb;
  logic signed [ERR_W-1:0] err;
  logic                    fbPulse;

  adpll_ctrl #(
    .ERR_W   (ERR_W),
    .LOCK_RUN(LOCK_RUN)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .refIn     (refIn),
    .fbPulse   (fbPulse),
    .err       (err),
    .lockThresh(lockThresh),
    .strb      (strb),
    .locked    (locked)
  );

  adpll_dp #(
    .NCO_W    (NCO_W),
    .ERR_W    (ERR_W),
    .DIV_W    (DIV_W),
    .FREE_WORD(FREE_WORD),
    .WORD_MIN (1)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .divN    (divN),
    .err     (err),
    .ctrlWord(ctrlWord),
    .clkOut  (clkOut),
    .fbPulse (fbPulse)
  );

endmodule

// File: rtl/adpll_loop_chk.sv
module adpll_loop_chk #(
  parameter int NCO_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             refIn,
  input logic [NCO_W-1:0] ctrlWord,
  input logic             locked,
  input logic             countUp,
  input logic             countDn
);

  logic refPrevC;
  logic refEdgeC;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) refPrevC <= 1'b0;
    else        refPrevC <= refIn;
  end

  assign refEdgeC = refIn & ~refPrevC;

  // R3: detector never in both directions
  a_r3_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(countUp && countDn));

  // R5: word never leaves the clamp range
  a_r5_word_floor: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlWord != '0);

  // R5: word only moves on a reference edge
  a_r5_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !refEdgeC |=> $stable(ctrlWord));

  // R7: lock flag only changes on a reference edge
  a_r7_lock_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(locked) |-> $past(refEdgeC));

endmodule

bind adpll_loop adpll_loop_chk #(.NCO_W(NCO_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .refIn   (refIn),
  .ctrlWord(ctrlWord),
  .locked  (locked),
  .countUp (strb.countUp),
  .countDn (strb.countDn)
);

// File: tb/adpll_loop_bench.sv
module adpll_loop_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       refIn = 1'b0;
  logic [3:0] divN = 4'd1;
  logic [9:0] lockThresh = 10'd1023;
  logic       clkOut;
  logic [4:0] ctrlWord;
  logic       locked;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adpll_loop u_adpll_loop (
    .clk(clk), .rst_n(rst_n), .refIn(refIn), .divN(divN),
    .lockThresh(lockThresh), .clkOut(clkOut), .ctrlWord(ctrlWord),
    .locked(locked)
  );

  // behavioural reference model
  int mRefPrev, mSt, mTdc, mAcc, mGood, mLock, mPhase, mClk, mDiv, mFb;

  always @(posedge clk) begin
    if (!rst_n) begin
      mRefPrev = 0; mSt = 0; mTdc = 0; mAcc = 20; mGood = 0; mLock = 0;
      mPhase = 0; mClk = 0; mDiv = 0; mFb = 0;
    end else begin
      int rEdge, step, e, nTdc, nAcc, nGood, nLock, nSt, sum, eff, term, nDiv, mag;
      rEdge = (refIn && !mRefPrev) ? 1 : 0;
      step  = (mSt == 1) ? 1 : (mSt == 2) ? -1 : 0;
      e     = mTdc;
      nTdc  = (rEdge ? 0 : mTdc) + step;
      if (nTdc > 511) nTdc = 511;
      if (nTdc < -511) nTdc = -511;
      nAcc = mAcc; nGood = mGood; nLock = mLock;
      if (rEdge) begin
        nAcc = mAcc + e;
        if (nAcc < 1) nAcc = 1;
        if (nAcc > 31) nAcc = 31;
        mag = (e < 0) ? -e : e;
        if (mag <= int'(lockThresh)) nGood = (mGood >= 4) ? 4 : mGood + 1;
        else nGood = 0;
        nLock = (nGood == 4) ? 1 : 0;
      end
      nSt = mSt;
      if (mSt == 0) begin
        if (rEdge && !mFb) nSt = 1;
        else if (mFb && !rEdge) nSt = 2;
      end else if (mSt == 1) begin
        if (mFb) nSt = 0;
      end else begin
        if (rEdge) nSt = 0;
      end
      sum  = mPhase + mAcc;
      eff  = (divN == 0) ? 1 : int'(divN);
      term = (mDiv >= eff - 1) ? 1 : 0;
      nDiv = mDiv;
      if (sum >= 32) nDiv = term ? 0 : mDiv + 1;
      mFb    = (sum >= 32 && term) ? 1 : 0;
      mClk   = (sum >= 32) ? 1 : 0;
      mPhase = sum % 32;
      mDiv   = nDiv;
      mSt = nSt; mTdc = nTdc; mAcc = nAcc; mGood = nGood; mLock = nLock;
      mRefPrev = refIn;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(clkOut == mClk[0], "R2/R6 clkOut vs model", int'(clkOut), mClk);
      check(int'(ctrlWord) == mAcc, "R4/R5 ctrlWord vs model", int'(ctrlWord), mAcc);
      check(locked == mLock[0], "R7 locked vs model", int'(locked), mLock);
    end
  end

  task automatic refPulses(input int period, input int count);
    for (int p = 0; p < count; p++) begin
      for (int c = 0; c < period; c++) begin
        @(negedge clk);
        refIn = (c < period / 2);
      end
    end
  endtask

  task automatic finishRun();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    int highs;
    repeat (3) @(negedge clk);
    // R1: reset values
    check(ctrlWord == 5'd20, "R1 reset ctrlWord", int'(ctrlWord), 20);
    check(locked == 1'b0, "R1 reset locked", int'(locked), 0);
    check(clkOut == 1'b0, "R1 reset clkOut", int'(clkOut), 0);
    rst_n = 1'b1;

    // R2: free run with no reference edges
    highs = 0;
    for (int c = 0; c < 320; c++) begin
      @(negedge clk);
      if (clkOut) highs++;
    end
    check(highs == 200, "R2 free-run pulse count", highs, 200);
    check(ctrlWord == 5'd20, "R5 word held without reference", int'(ctrlWord), 20);

    // R7: lock after four in-band edges
    refPulses(40, 3);
    check(locked == 1'b0, "R7 not locked after 3 edges", int'(locked), 0);
    refPulses(40, 1);
    check(locked == 1'b1, "R7 locked after 4 edges", int'(locked), 1);

    // R8 floor: slow reference, divide-by-one, zero band
    lockThresh = 10'd0;
    divN = 4'd1;
    refPulses(200, 6);
    check(ctrlWord == 5'd1, "R8 word pinned at floor", int'(ctrlWord), 1);
    check(locked == 1'b0, "R7 lock dropped out of band", int'(locked), 0);

    // R8 ceiling: fast reference, divide-by-eight
    divN = 4'd8;
    refPulses(8, 60);
    check(ctrlWord == 5'd31, "R8 word pinned at ceiling", int'(ctrlWord), 31);

    // R6: divN of zero and small ratios, wider band
    lockThresh = 10'd40;
    divN = 4'd0;
    refPulses(30, 40);
    divN = 4'd3;
    refPulses(60, 30);
    divN = 4'd2;
    refPulses(17, 40);
    check(ctrlWord >= 5'd1, "R5 word within range", int'(ctrlWord), 1);

    repeat (5) @(negedge clk);
    finishRun();
  end

endmodule